// File: doc/BRIEF.md
# Unframed Parallel Data Port Controller

This block connects an external parallel data bus to an internal FIFO without any periodic framing. Once a transfer has started, it moves one word per port clock in either direction. On receive, each sampled bus word is written into the receive FIFO. On transmit, one word per cycle is popped from the transmit FIFO and driven onto the bus.

What sets it apart is how a transfer starts. A receive can start internally, a fixed number of clocks after enable. It can instead wait for a single rising edge on an external start pin, which is only ever an input. A transmit always starts internally, on the first cycle in which the transmit FIFO reports full. After the start, the start pin is ignored. Later changes in FIFO level also do not stop the transfer.

An optional skip mode keeps only every other received sample. A sticky error flag records a receive write into a full FIFO, or a transmit read from an empty one. Dropping the enable returns the controller to idle, clears the error flag and re-arms both start conditions.

Top module: `unframed_pport`

## Requirements
- R1: While rst_ni is low and after its release with en_i low, rxf_wr_o, txf_rd_o, pdata_oe_o, err_o and pdata_o are all 0.
- R2: With dir_tx_i=0 and trig_ext_i=0, the first word written to the receive FIFO is the bus value sampled at the (START_LAT+1)-th rising edge after the first edge that sees en_i high. After that a word is written on every clock, through the edge at which en_i is first seen low.
- R3: With skip_en_i=1 on receive, only the first qualifying sample and every second one after it are written (samples 0, 2, 4, ... counted from the first capture).
- R4: With dir_tx_i=0 and trig_ext_i=1, nothing is written until a rising edge on trig_pin_i, which passes through a two-flop synchronizer. If the pin is first sampled high at edge k, the first word written is the bus value at edge k+3. Without a rising edge, nothing is written.
- R5: Once a receive has started, further pulses on trig_pin_i do not stop, restart or realign the stream. In internal-trigger mode the pin has no effect at all.
- R6: With dir_tx_i=1, txf_rd_o and pdata_oe_o stay 0 while the transmit FIFO is not full, even when it holds data.
- R7: Once the transmit has started, txf_rd_o is high on every clock. The word at the FIFO head at edge n appears on pdata_o after edge n with pdata_oe_o high. Streaming continues after the full flag drops.
- R8: err_o goes to 1 the cycle after a receive write with rxf_full_i high, or after a transmit read with txf_empty_i high. It stays 1 while en_i remains high.
- R9: When en_i is seen low, the controller returns to idle and clears err_o. A following enable needs a new trigger edge or FIFO-full condition to start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low returns to idle and re-arms |
| dir_tx_i | input | 1 | 1 = transmit, 0 = receive |
| trig_ext_i | input | 1 | Receive start source: 0 internal, 1 external pin |
| skip_en_i | input | 1 | Receive keeps alternate samples only |
| trig_pin_i | input | 1 | External start pin (asynchronous) |
| pdata_i | input | DW | Parallel bus, receive side |
| pdata_o | output | DW | Parallel bus, transmit side |
| pdata_oe_o | output | 1 | Bus drive enable during transmit |
| rxf_wr_o | output | 1 | Receive FIFO write strobe |
| rxf_wdata_o | output | DW | Receive FIFO write data |
| rxf_full_i | input | 1 | Receive FIFO full |
| txf_rd_o | output | 1 | Transmit FIFO read (pop) strobe |
| txf_rdata_i | input | DW | Transmit FIFO head word (first-word fall-through) |
| txf_full_i | input | 1 | Transmit FIFO full |
| txf_empty_i | input | 1 | Transmit FIFO empty |
| err_o | output | 1 | Sticky overflow/underflow flag |

## Verification
The assertions check several properties on every cycle. A running state holds while enabled. An external-mode receive cannot start without a synchronized edge, and a transmit cannot start without full. Disabling always lands in idle. Skip mode never writes twice in a row, the bus enable follows the read strobe, and the error flag is sticky. Other behaviour is only visible in the bench's scenarios: the exact sample on which capture begins for each trigger source, the order and values of words on both sides, the effect of the three-edge trigger latency, and re-arming across consecutive runs.

// File: rtl/upp_pkg.sv
package upp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARM    = 2'd1,
    ST_RUN_RX = 2'd2,
    ST_RUN_TX = 2'd3
  } upp_state_e;
endpackage

// File: rtl/upp_trig_sync.sv
module upp_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) hist_q <= 1'b0;
    else         hist_q <= sync_q[LAST];

  assign rise_o = sync_q[LAST] & ~hist_q;

  p_rise_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/upp_start_fsm.sv
module upp_start_fsm
  import upp_pkg::*;
#(
  parameter int START_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic dir_tx_i,
  input  logic trig_ext_i,
  input  logic trig_rise_i,
  input  logic txf_full_i,
  output logic run_rx_o,
  output logic run_tx_o
);
  localparam int CW = (START_LAT < 2) ? 1 : $clog2(START_LAT + 1);
  localparam logic [CW-1:0] LAT_LAST = CW'(START_LAT - 1);

  upp_state_e state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_ARM;
          cnt_q   <= '0;
        end
        ST_ARM: begin
          if (dir_tx_i) begin
            if (txf_full_i) state_q <= ST_RUN_TX;
          end else if (trig_ext_i) begin
            if (trig_rise_i) state_q <= ST_RUN_RX;
          end else if (cnt_q == LAT_LAST) begin
            state_q <= ST_RUN_RX;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;  // running states hold until disabled
      endcase
    end
  end

  assign run_rx_o = (state_q == ST_RUN_RX);
  assign run_tx_o = (state_q == ST_RUN_TX);

  p_run_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RUN_RX || state_q == ST_RUN_TX) && en_i) |=> $stable(state_q));
  p_ext_waits_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM && en_i && !dir_tx_i && trig_ext_i && !trig_rise_i)
      |=> state_q != ST_RUN_RX);
  p_tx_needs_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARM && !txf_full_i) |=> state_q != ST_RUN_TX);
  p_disable_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ST_IDLE);
endmodule

// File: rtl/upp_rx_path.sv
module upp_rx_path #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          skip_en_i,
  input  logic [DW-1:0] pdata_i,
  input  logic          rxf_full_i,
  output logic          wr_o,
  output logic [DW-1:0] wdata_o,
  output logic          ovf_o
);
  logic phase_q;
  logic keep;

  assign keep  = !skip_en_i || !phase_q;
  assign ovf_o = run_i && keep && rxf_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      wr_o    <= 1'b0;
      wdata_o <= '0;
    end else if (!run_i) begin
      phase_q <= 1'b0;
      wr_o    <= 1'b0;
    end else begin
      wr_o    <= keep;
      phase_q <= skip_en_i ? ~phase_q : 1'b0;
      if (keep) wdata_o <= pdata_i;
    end
  end

  p_wr_in_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(run_i));
  p_skip_alt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && skip_en_i && $stable(skip_en_i)) |=> !wr_o);
endmodule

// File: rtl/upp_tx_path.sv
module upp_tx_path #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] txf_rdata_i,
  input  logic          txf_empty_i,
  output logic          rd_o,
  output logic [DW-1:0] pdata_o,
  output logic          oe_o,
  output logic          udf_o
);
  assign rd_o  = run_i;
  assign udf_o = run_i && txf_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o    <= 1'b0;
      pdata_o <= '0;
    end else begin
      oe_o <= run_i;
      if (run_i) pdata_o <= txf_rdata_i;
    end
  end

  p_oe_follows_rd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> oe_o);
  p_oe_needs_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(rd_o));
endmodule

// File: rtl/unframed_pport.sv
module unframed_pport #(
  parameter int DW          = 16,
  parameter int START_LAT   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          dir_tx_i,
  input  logic          trig_ext_i,
  input  logic          skip_en_i,
  input  logic          trig_pin_i,
  input  logic [DW-1:0] pdata_i,
  output logic [DW-1:0] pdata_o,
  output logic          pdata_oe_o,
  output logic          rxf_wr_o,
  output logic [DW-1:0] rxf_wdata_o,
  input  logic          rxf_full_i,
  output logic          txf_rd_o,
  input  logic [DW-1:0] txf_rdata_i,
  input  logic          txf_full_i,
  input  logic          txf_empty_i,
  output logic          err_o
);
  logic trig_rise, run_rx, run_tx, ovf, udf;

  upp_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .pin_i(trig_pin_i), .rise_o(trig_rise)
  );

  upp_start_fsm #(.START_LAT(START_LAT)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .dir_tx_i   (dir_tx_i),
    .trig_ext_i (trig_ext_i),
    .trig_rise_i(trig_rise),
    .txf_full_i (txf_full_i),
    .run_rx_o   (run_rx),
    .run_tx_o   (run_tx)
  );

  upp_rx_path #(.DW(DW)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_rx),
    .skip_en_i (skip_en_i),
    .pdata_i   (pdata_i),
    .rxf_full_i(rxf_full_i),
    .wr_o      (rxf_wr_o),
    .wdata_o   (rxf_wdata_o),
    .ovf_o     (ovf)
  );

  upp_tx_path #(.DW(DW)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_tx),
    .txf_rdata_i(txf_rdata_i),
    .txf_empty_i(txf_empty_i),
    .rd_o       (txf_rd_o),
    .pdata_o    (pdata_o),
    .oe_o       (pdata_oe_o),
    .udf_o      (udf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          err_o <= 1'b0;
    else if (!en_i)       err_o <= 1'b0;
    else if (ovf || udf)  err_o <= 1'b1;
  end

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && en_i) |=> err_o);
endmodule

// File: tb/unframed_pport_test.sv
`timescale 1ns/1ps
module unframed_pport_test;
  localparam int DW  = 16;
  localparam int LAT = 2;
  localparam int FD  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic en = 0, dir_tx = 0, trig_ext = 0, skip_en = 0, trig_pin = 0, rxf_full = 0;
  logic txf_full = 0, txf_empty = 1;
  logic [DW-1:0] pdata_in = '0, txf_rdata = '0;
  logic [DW-1:0] pdata_out, rxf_wdata;
  logic pdata_oe, rxf_wr, txf_rd, err;

  unframed_pport #(.DW(DW), .START_LAT(LAT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .dir_tx_i(dir_tx), .trig_ext_i(trig_ext),
    .skip_en_i(skip_en), .trig_pin_i(trig_pin), .pdata_i(pdata_in), .pdata_o(pdata_out),
    .pdata_oe_o(pdata_oe), .rxf_wr_o(rxf_wr), .rxf_wdata_o(rxf_wdata), .rxf_full_i(rxf_full),
    .txf_rd_o(txf_rd), .txf_rdata_i(txf_rdata), .txf_full_i(txf_full),
    .txf_empty_i(txf_empty), .err_o(err)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] rx_exp[$];
  logic [DW-1:0] tx_exp[$];
  logic [DW-1:0] tx_fifo[$];
  int tx_req = 0;
  int rx_wr_cnt = 0;
  logic [DW-1:0] tx_next = 16'h7000;
  bit rd_prev = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: receive scoreboard and transmit FIFO model
  always @(negedge clk) begin : mon
    logic [DW-1:0] e;
    if (rst_n) begin
      if (rxf_wr) begin
        rx_wr_cnt++;
        if (rx_exp.size() == 0) chk(0, "R2 unexpected receive write", int'(rxf_wdata), 0);
        else begin
          e = rx_exp.pop_front();
          chk(rxf_wdata == e, "R2/R3/R4 captured word", int'(rxf_wdata), int'(e));
        end
      end
      if (rd_prev && tx_fifo.size() > 0) begin
        void'(tx_fifo.pop_front());
        e = tx_exp.pop_front();
        chk(pdata_oe && pdata_out == e, "R7 transmitted word", int'(pdata_out), int'(e));
      end
      if (tx_req > 0 && tx_fifo.size() < FD) begin
        tx_fifo.push_back(tx_next);
        tx_exp.push_back(tx_next);
        tx_next = tx_next + 1'b1;
        tx_req--;
      end
      txf_full  = (tx_fifo.size() == FD);
      txf_empty = (tx_fifo.size() == 0);
      txf_rdata = (tx_fifo.size() > 0) ? tx_fifo[0] : '0;
      rd_prev   = txf_rd;
    end
  end

  task automatic drive_rx(input int n, input bit skip, input bit ext, input int trig_at,
                          input int full_at, input logic [DW-1:0] base);
    int j0 = ext ? trig_at + 3 : LAT + 1;
    int pushed = 0;
    int wr0 = rx_wr_cnt;
    for (int j = 0; j <= n; j++) begin
      @(negedge clk);
      en       = (j < n);
      dir_tx   = 0;
      skip_en  = skip;
      trig_ext = ext;
      pdata_in = base + DW'(j);
      trig_pin = (j == trig_at || j == trig_at + 1 || j == trig_at + 7 || j == trig_at + 13);
      rxf_full = (full_at >= 0 && j == full_at);
      if (j >= j0 && (!skip || ((j - j0) % 2 == 0))) begin
        rx_exp.push_back(base + DW'(j));
        pushed++;
      end
      if (full_at >= 0 && j == full_at) chk(err == 0, "R8 flag clear before overflow", err, 0);
      if (full_at >= 0 && j == full_at + 3) chk(err == 1, "R8 overflow sets flag", err, 1);
      if (full_at >= 0 && j == full_at + 8) chk(err == 1, "R8 flag sticky", err, 1);
      if (full_at < 0 && j == n - 1) chk(err == 0, "R8 no false error", err, 0);
    end
    @(negedge clk);
    trig_pin = 0;
    rxf_full = 0;
    repeat (3) @(negedge clk);
    chk(rx_exp.size() == 0, "R2 all expected words written", rx_exp.size(), 0);
    chk(rx_wr_cnt - wr0 == pushed, "R2/R3 write count", rx_wr_cnt - wr0, pushed);
    chk(err == 0, "R9 disable clears flag", err, 0);
  endtask

  task automatic drive_tx(input int pre, input int total);
    @(negedge clk);
    dir_tx = 1; trig_ext = 0; skip_en = 0;
    tx_req = pre;
    repeat (pre + 2) @(negedge clk);
    en = 1;
    repeat (6) begin
      @(negedge clk);
      chk(!txf_rd && !pdata_oe, "R6 no read before full", {txf_rd, pdata_oe}, 0);
    end
    tx_req = tx_req + (total - pre);
    for (int k = 0; k < 200 && !(tx_req == 0 && tx_fifo.size() == 0); k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(err == 1, "R8 underflow sets flag", err, 1);
    chk(pdata_oe == 1 && txf_rd == 1, "R7 stream continues after full drops", {txf_rd, pdata_oe}, 3);
    en = 0;
    repeat (2) @(negedge clk);
    chk(err == 0, "R9 disable clears flag", err, 0);
    chk(!txf_rd && !pdata_oe, "R9 idle after disable", {txf_rd, pdata_oe}, 0);
    chk(tx_exp.size() == 0, "R7 all words sent", tx_exp.size(), 0);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(!rxf_wr && !txf_rd && !pdata_oe && !err && pdata_out == 0, "R1 outputs in reset",
        {rxf_wr, txf_rd, pdata_oe, err}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!rxf_wr && !txf_rd && !pdata_oe && !err, "R1 idle after reset",
        {rxf_wr, txf_rd, pdata_oe, err}, 0);

    drive_rx(20, 0, 0, 1, -1, 16'h1000);   // R2 internal start, R5 pin ignored
    drive_rx(21, 1, 0, 1, -1, 16'h2000);   // R3 skip
    drive_rx(24, 0, 1, 5, -1, 16'h3000);   // R4 external edge, R5 later pulses
    drive_rx(24, 1, 1, 4, -1, 16'h4000);   // R9 re-arm with skip
    drive_rx(16, 0, 1, 100, -1, 16'h5000); // R4 no edge, no writes
    drive_rx(20, 0, 0, 1, 8, 16'h6000);    // R8 overflow
    drive_tx(2, 4);                        // R6 gate, R7, R8 underflow
    drive_tx(0, 10);                       // R9 re-arm on transmit

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule